// File: doc/BRIEF.md
# Oscillator Recalibration Interval Timer

This block paces periodic recalibration of a slow on-chip oscillator. Software programs a 7-bit interval expressed in quarter-second units and then fires a start strobe. When the programmed time has elapsed, the block flags a timeout once and returns to idle. A stop strobe abandons the wait at any time. The block only measures the interval. Running the calibration is left to the surrounding logic.

Three events are reported: started (index 0), stopped (index 1) and timeout (index 2). Each event sets a sticky flag that stays high until its clear strobe. Each event also produces a single-cycle pulse that other blocks can subscribe to. An interrupt request combines the flags with a per-event enable mask. The length of a quarter second is fixed at build time as a number of clock cycles. The countdown length is the interval multiplied by that number. The interval is captured when the timer starts.

Top module: `cal_interval_timer`

## Requirements
- R1: After reset, all three flags in `evt_o` (bit 0 started, bit 1 stopped, bit 2 timeout), all pulses in `pub_o` and `irq_o` are low, and the timer is idle.
- R2: A start strobe sampled on a clock edge without a stop strobe sets `evt_o[0]` at that edge and pulses `pub_o[0]` for that one cycle.
- R3: Starting from idle with interval value V, the timeout flag `evt_o[2]` and pulse `pub_o[2]` appear exactly V×TICKS_PER_QUARTER edges after the start edge. When V is 0 they appear 1 edge after the start edge.
- R4: A start strobe while the countdown is running still raises the started flag and pulse, but does not reload the countdown. The timeout keeps the time set by the first start.
- R5: A stop strobe cancels any pending countdown, so no timeout follows. It sets `evt_o[1]` and pulses `pub_o[1]` at that edge, even when the timer was already idle.
- R6: When start and stop are sampled on the same edge, stop wins. Only the stopped event is raised, and no countdown begins.
- R7: The interval input is sampled only at a start from idle. Changing it while the countdown runs does not change when the timeout occurs.
- R8: After a timeout the timer stays idle. No further timeout occurs without a new start.
- R9: `irq_o` is high whenever at least one flag in `evt_o` is set and its bit in `irq_en_i` is also set (same bit order as the flags). Otherwise it is low.
- R10: A flag stays set until its bit in `evt_clr_i` is strobed. When an event and its clear strobe arrive on the same edge, the event wins and the flag stays set.
- R11: Each `pub_o` bit is high for exactly one cycle per event.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| interval_i | input | 7 | Interval in quarter-second units, captured at start |
| start_i | input | 1 | Start task strobe |
| stop_i | input | 1 | Stop task strobe |
| evt_clr_i | input | 3 | Per-flag clear strobes |
| irq_en_i | input | 3 | Per-event interrupt enables |
| evt_o | output | 3 | Sticky event flags: started, stopped, timeout |
| pub_o | output | 3 | One-cycle event pulses |
| irq_o | output | 1 | Interrupt request |

## Verification
The hardest case to reach is a start that arrives while a countdown is already running. It has to be shown that this start raises the started event and yet leaves the timeout edge where the first start put it. The bench records the edge of the first start from a free-running cycle counter. It fires a second start part way through the wait and requires the timeout to land exactly on the time set by the first start. It also fires stop strobes in the middle of a countdown, and start and stop on the same edge. After each of these it waits well past the longest possible timeout to confirm that no timeout appears.

// File: rtl/cit_pkg.sv
package cit_pkg;
    localparam int NUM_EV     = 3;
    localparam int EV_STARTED = 0;
    localparam int EV_STOPPED = 1;
    localparam int EV_TIMEOUT = 2;

    typedef struct packed {
        logic go;
        logic halt;
    } task_t;
endpackage

// File: rtl/cit_countdown.sv
module cit_countdown #(
    parameter int LOAD_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_i,
    input  logic [LOAD_W-1:0] load_val_i,
    input  logic              cancel_i,
    output logic              busy_o,
    output logic              expire_o
);
    typedef struct packed {
        logic              busy;
        logic [LOAD_W-1:0] rem;
    } cnt_t;

    cnt_t cnt_d, cnt_q;
    logic last_tick;

    always_comb begin
        cnt_d     = cnt_q;
        last_tick = cnt_q.busy && (cnt_q.rem <= LOAD_W'(1));
        expire_o  = last_tick && !cancel_i;
        if (cancel_i) begin
            cnt_d.busy = 1'b0;
            cnt_d.rem  = '0;
        end else if (cnt_q.busy) begin
            if (last_tick) begin
                cnt_d.busy = 1'b0;
                cnt_d.rem  = '0;
            end else begin
                cnt_d.rem = cnt_q.rem - LOAD_W'(1);
            end
        end else if (load_i) begin
            cnt_d.busy = 1'b1;
            cnt_d.rem  = load_val_i;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign busy_o = cnt_q.busy;
endmodule

// File: rtl/cit_event_bank.sv
module cit_event_bank #(
    parameter int NUM = 3
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [NUM-1:0] set_i,
    input  logic [NUM-1:0] clr_i,
    input  logic [NUM-1:0] en_i,
    output logic [NUM-1:0] flag_o,
    output logic [NUM-1:0] pulse_o,
    output logic           irq_o
);
    for (genvar g = 0; g < NUM; g++) begin : g_ev
        typedef struct packed {
            logic flag;
            logic pulse;
        } ev_t;

        ev_t ev_d, ev_q;

        always_comb begin
            ev_d.pulse = set_i[g];
            if (set_i[g])      ev_d.flag = 1'b1;
            else if (clr_i[g]) ev_d.flag = 1'b0;
            else               ev_d.flag = ev_q.flag;
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) ev_q <= '0;
            else        ev_q <= ev_d;
        end

        assign flag_o[g]  = ev_q.flag;
        assign pulse_o[g] = ev_q.pulse;
    end

    assign irq_o = |(flag_o & en_i);
endmodule

// File: rtl/cal_interval_timer.sv
module cal_interval_timer #(
    parameter int INTERVAL_W        = 7,
    parameter int TICKS_PER_QUARTER = 62_500_000
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [INTERVAL_W-1:0] interval_i,
    input  logic                  start_i,
    input  logic                  stop_i,
    input  logic [2:0]            evt_clr_i,
    input  logic [2:0]            irq_en_i,
    output logic [2:0]            evt_o,
    output logic [2:0]            pub_o,
    output logic                  irq_o
);
    import cit_pkg::*;

    localparam int LOAD_W = INTERVAL_W + $clog2(TICKS_PER_QUARTER + 1);

    task_t              tsk;
    logic               busy;
    logic               expire;
    logic [LOAD_W-1:0]  load_val;
    logic [NUM_EV-1:0]  ev_set;

    always_comb begin
        tsk.halt = stop_i;
        tsk.go   = start_i && !stop_i;
        load_val = LOAD_W'(interval_i) * LOAD_W'(TICKS_PER_QUARTER);
        ev_set                = '0;
        ev_set[EV_STARTED]    = tsk.go;
        ev_set[EV_STOPPED]    = tsk.halt;
        ev_set[EV_TIMEOUT]    = expire;
    end

    cit_countdown #(.LOAD_W(LOAD_W)) u_cnt (
        .clk        (clk),
        .rst_n      (rst_n),
        .load_i     (tsk.go),
        .load_val_i (load_val),
        .cancel_i   (tsk.halt),
        .busy_o     (busy),
        .expire_o   (expire)
    );

    cit_event_bank #(.NUM(NUM_EV)) u_ev (
        .clk     (clk),
        .rst_n   (rst_n),
        .set_i   (ev_set),
        .clr_i   (evt_clr_i),
        .en_i    (irq_en_i),
        .flag_o  (evt_o),
        .pulse_o (pub_o),
        .irq_o   (irq_o)
    );
endmodule

// File: rtl/cit_checker.sv
module cit_checker (
    input logic       clk,
    input logic       rst_n,
    input logic       start_i,
    input logic       stop_i,
    input logic [2:0] evt_clr_i,
    input logic [2:0] irq_en_i,
    input logic [2:0] evt_o,
    input logic [2:0] pub_o,
    input logic       irq_o
);
    p_started_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && !stop_i) |=> (evt_o[0] && pub_o[0]));

    p_stop_event_r5: assert property (@(posedge clk) disable iff (!rst_n)
        stop_i |=> (evt_o[1] && pub_o[1] && !pub_o[2]));

    p_stop_wins_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && stop_i) |=> !pub_o[0]);

    p_irq_high_r9: assert property (@(posedge clk) disable iff (!rst_n)
        ((evt_o & irq_en_i) != 3'b000) |-> irq_o);

    p_irq_low_r9: assert property (@(posedge clk) disable iff (!rst_n)
        ((evt_o & irq_en_i) == 3'b000) |-> !irq_o);

    p_pulse_has_flag_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (pub_o != 3'b000) |-> ((pub_o & evt_o) == pub_o));

    p_clear_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (evt_clr_i[1] && !stop_i) |=> !evt_o[1]);
endmodule

bind cal_interval_timer cit_checker u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .start_i   (start_i),
    .stop_i    (stop_i),
    .evt_clr_i (evt_clr_i),
    .irq_en_i  (irq_en_i),
    .evt_o     (evt_o),
    .pub_o     (pub_o),
    .irq_o     (irq_o)
);

// File: tb/cal_interval_timer_tb.sv
module cal_interval_timer_tb;
    localparam int TPQ = 3;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [6:0] interval_i = '0;
    logic       start_i = 1'b0;
    logic       stop_i = 1'b0;
    logic [2:0] evt_clr_i = '0;
    logic [2:0] irq_en_i = '0;
    logic [2:0] evt_o;
    logic [2:0] pub_o;
    logic       irq_o;

    int total = 0;
    int bad = 0;
    int cyc = 0;
    bit done = 0;

    always #2 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    cal_interval_timer #(.INTERVAL_W(7), .TICKS_PER_QUARTER(TPQ)) u_dut (
        .clk(clk), .rst_n(rst_n), .interval_i(interval_i), .start_i(start_i),
        .stop_i(stop_i), .evt_clr_i(evt_clr_i), .irq_en_i(irq_en_i),
        .evt_o(evt_o), .pub_o(pub_o), .irq_o(irq_o)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic strobe(input bit s, input bit p, input logic [2:0] c);
        start_i = s; stop_i = p; evt_clr_i = c;
        step();
        start_i = 0; stop_i = 0; evt_clr_i = 0;
    endtask

    task automatic clear_all();
        strobe(0, 0, 3'b111);
    endtask

    // waits up to lim edges for a timeout pulse; returns elapsed edges since t0 or -1
    task automatic wait_to(input int t0, input int lim, output int el);
        el = -1;
        for (int k = 0; k < lim; k++) begin
            step();
            if (pub_o[2]) begin
                el = cyc - t0;
                break;
            end
        end
    endtask

    initial begin
        #1_000_000;
        if (!done) begin
            bad++; total++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        int t0, el, exp;
        repeat (3) @(negedge clk);
        chk(evt_o == 0 && pub_o == 0 && irq_o == 0, "R1 reset outputs", {evt_o, pub_o, irq_o}, 0);
        rst_n = 1;
        step();
        chk(evt_o == 0 && pub_o == 0, "R1 after release", {evt_o, pub_o}, 0);

        // R3 sweep over every interval, R2 and R11 along the way, R8 no restart
        for (int iv = 0; iv < 128; iv++) begin
            clear_all();
            interval_i = 7'(iv);
            strobe(1, 0, 0);
            t0 = cyc;
            chk(evt_o[0] && pub_o[0], "R2 started flag+pulse", {evt_o[0], pub_o[0]}, 3);
            exp = (iv == 0) ? 1 : iv * TPQ;
            if (iv > 0) begin
                step();
                chk(!pub_o[0] && evt_o[0], "R11 pulse one cycle, R10 flag sticky", {pub_o[0], evt_o[0]}, 1);
                if (iv * TPQ == 1) exp = -2;
            end
            if (exp == -2) begin
                chk(pub_o[2], "R3 timeout at 1", pub_o[2], 1);
            end else begin
                wait_to(t0, 500, el);
                chk(el == exp, "R3 timeout edge count", el, exp);
            end
            if (iv == 5 || iv == 0) begin
                step();
                chk(!pub_o[2] && evt_o[2], "R11 timeout pulse one cycle", {pub_o[2], evt_o[2]}, 1);
                clear_all();
                wait_to(t0, 40, el);
                chk(el == -1 && evt_o[2] == 0, "R8 no restart", el, -1);
            end
        end

        // R7 interval change while running
        clear_all();
        interval_i = 7'd4;
        strobe(1, 0, 0);
        t0 = cyc;
        interval_i = 7'd100;
        wait_to(t0, 500, el);
        chk(el == 4 * TPQ, "R7 interval sampled at start", el, 4 * TPQ);

        // R4 redundant start
        clear_all();
        interval_i = 7'd10;
        strobe(1, 0, 0);
        t0 = cyc;
        repeat (10) step();
        clear_all();
        interval_i = 7'd1;
        strobe(1, 0, 0);
        chk(pub_o[0] && evt_o[0], "R4 redundant start raises started", {pub_o[0], evt_o[0]}, 3);
        wait_to(t0, 500, el);
        chk(el == 10 * TPQ, "R4 no reload", el, 10 * TPQ);

        // R5 stop mid-count
        clear_all();
        interval_i = 7'd5;
        strobe(1, 0, 0);
        repeat (5) step();
        strobe(0, 1, 0);
        chk(evt_o[1] && pub_o[1], "R5 stop event", {evt_o[1], pub_o[1]}, 3);
        t0 = cyc;
        wait_to(t0, 60, el);
        chk(el == -1 && !evt_o[2], "R5 stop cancels timeout", el, -1);

        // R5 stop while idle
        clear_all();
        strobe(0, 1, 0);
        chk(evt_o == 3'b010 && pub_o == 3'b010, "R5 stop when idle", {evt_o, pub_o}, 6'b010010);

        // R6 start and stop together
        clear_all();
        interval_i = 7'd1;
        strobe(1, 1, 0);
        chk(evt_o == 3'b010 && pub_o == 3'b010, "R6 stop wins", {evt_o, pub_o}, 6'b010010);
        t0 = cyc;
        wait_to(t0, 20, el);
        chk(el == -1, "R6 no countdown", el, -1);

        // R10 set beats clear
        clear_all();
        interval_i = 7'd20;
        strobe(1, 0, 3'b001);
        chk(evt_o[0], "R10 set beats clear", evt_o[0], 1);
        strobe(0, 0, 3'b001);
        chk(!evt_o[0], "R10 clear works", evt_o[0], 0);
        strobe(0, 1, 0);

        // R9 irq sweep: all flags set, then only stopped flag set
        clear_all();
        interval_i = 7'd0;
        strobe(1, 0, 0);
        step();
        strobe(0, 1, 0);
        for (int en = 0; en < 8; en++) begin
            irq_en_i = 3'(en);
            #1;
            chk(irq_o == (en != 0), "R9 irq all flags", irq_o, en != 0);
        end
        strobe(0, 0, 3'b101);
        for (int en = 0; en < 8; en++) begin
            irq_en_i = 3'(en);
            #1;
            chk(irq_o == en[1], "R9 irq stopped flag only", irq_o, en[1]);
        end
        irq_en_i = 0;

        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule